// File: doc/BRIEF.md
# Output Divider Sync Controller

This block decides when a set of output clock dividers (two by default) leaves a static, held state. After reset every divider is held with its counter at zero and its output low. The dividers start running only after a sync event has been applied. A sync event can come from one of three places. The first is a manual strobe tied to a register-update event. The second is the rising edge of an asynchronous reference sync input. The third is an automatic trigger on the rising edge of a frequency-lock or phase-lock flag. A sync event is applied only while the analog PLL reports that it is calibrated and locked, unless an override bit removes that condition. A request that arrives while the condition is not met is held pending.

Each channel has a mask bit. Setting the mask releases that divider at once, with no clock edge needed, and the channel then ignores sync events. The mask does not touch the driver-enable outputs; those follow their own configuration bits. Each divider divides by twice its programmed ratio, and a ratio of zero behaves as a ratio of one. While a sync is applied, all unmasked dividers clear together and restart on the same edge.

Top module: `odsync_top`

## Requirements
- R1: While reset is asserted and after it is released, every unmasked channel has `div_hold_o` high and `div_clk_o` low until the first sync is applied.
- R2: A released, unheld channel with ratio N (N = 0 is treated as 1) produces a `div_clk_o` that is low for N cycles and then high for N cycles, repeating. Counting j from 0 at the first cycle after `div_hold_o` falls, the output equals (j / N) mod 2.
- R3: With `cfg_src_ref_i` = 0, a one-cycle `upd_strobe_i` sampled at a clock edge applies a sync. `div_hold_o` is high for exactly the following cycle on every unmasked channel. With `cfg_src_ref_i` = 1, the strobe has no effect.
- R4: With `cfg_src_ref_i` = 1, a rising edge on `ref_sync_i` passes through a two-flop synchronizer and an edge detector. `div_hold_o` is high in the third sampled cycle after the edge and low in the two cycles before it. With `cfg_src_ref_i` = 0, `ref_sync_i` has no effect.
- R5: The 2-bit `cfg_auto_mode_i` selects the automatic trigger: 2'b01 = rising edge of `freq_lock_i`, 2'b10 = rising edge of `phase_lock_i`, 2'b00 and 2'b11 = none. The sync is applied in the cycle after the rising edge is sampled. A flag that stays high does not trigger again.
- R6: A set `cfg_mask_i[i]` drives `div_hold_o[i]` low combinationally, and that channel's hold stays low across every sync event.
- R7: `drv_en_o` always equals `cfg_out_en_i`. Changing `cfg_mask_i` never changes it.
- R8: A sync is applied only in a cycle that follows a clock edge where `apll_ok_i` or `cfg_lock_ovr_i` was high.
- R9: An unqualified request is kept pending while the automatic mode is 2'b01 or 2'b10. It is applied on the first edge where the qualification holds. It is discarded when the mode is 2'b00 or 2'b11.
- R10: All unmasked channels leave the hold on the same edge and start from a low output, whatever their ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mask_i | input | NUM_CH | Per-channel release/mask bits |
| cfg_src_ref_i | input | 1 | Manual sync source: 0 strobe, 1 reference edge |
| cfg_auto_mode_i | input | 2 | Automatic trigger selection |
| cfg_lock_ovr_i | input | 1 | Removes the PLL-lock qualification |
| cfg_out_en_i | input | NUM_CH | Driver-enable configuration |
| cfg_ratio_i | input | NUM_CH*DIV_W | Per-channel divide ratio, channel 0 in the low bits |
| upd_strobe_i | input | 1 | Register-update strobe, one cycle |
| ref_sync_i | input | 1 | Asynchronous reference sync input |
| freq_lock_i | input | 1 | Frequency-lock flag |
| phase_lock_i | input | 1 | Phase-lock flag |
| apll_ok_i | input | 1 | Analog PLL calibrated and locked |
| div_hold_o | output | NUM_CH | Per-channel divider hold/clear |
| div_clk_o | output | NUM_CH | Per-channel divided clock |
| drv_en_o | output | NUM_CH | Driver enable |

## Verification
The sharpest collisions come from a sync landing in the same cycle as another change. In one case a channel's mask changes while a strobe is applied. In another a pending request meets the cycle in which the PLL qualification comes back. The bench sets a mask on one channel and then strobes, and expects a hold vector with only the other channel high. It also leaves a request pending, raises the qualification at a chosen edge, and expects the hold in exactly the next cycle. A third case drops the automatic mode before raising the qualification, and the bench then expects no hold at all.

// File: rtl/odsync_pkg.sv
package odsync_pkg;

    typedef enum logic [1:0] {
        AUTO_OFF   = 2'b00,
        AUTO_FREQ  = 2'b01,
        AUTO_PHASE = 2'b10,
        AUTO_RSVD  = 2'b11
    } auto_mode_e;

    // Request controller state
    typedef struct packed {
        logic prev_freq;
        logic prev_phase;
        logic pending;
        logic sync;
    } req_state_t;

endpackage

// File: rtl/odsync_ref_sync.sv
module odsync_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } rs_state_t;

    rs_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (STAGES > 1) begin
            s_d.chain = {s_q.chain[STAGES-2:0], async_i};
        end else begin
            s_d.chain[0] = async_i;
        end
        s_d.last = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.chain[STAGES-1] & ~s_q.last;

endmodule

// File: rtl/odsync_req_ctl.sv
module odsync_req_ctl
    import odsync_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_ref_i,
    input  logic [1:0]        auto_mode_i,
    input  logic              lock_ovr_i,
    input  logic              apll_ok_i,
    input  logic              upd_strobe_i,
    input  logic              ref_rise_i,
    input  logic              freq_lock_i,
    input  logic              phase_lock_i,
    input  logic [NUM_CH-1:0] mask_i,
    output logic              sync_o,
    output logic [NUM_CH-1:0] released_o
);

    req_state_t        s_d, s_q;
    logic [NUM_CH-1:0] rel_d, rel_q;
    auto_mode_e        mode;
    logic              auto_on, auto_hit, man_hit, req, qual, fire;

    always_comb begin
        mode     = auto_mode_e'(auto_mode_i);
        auto_on  = (mode == AUTO_FREQ) || (mode == AUTO_PHASE);
        auto_hit = ((mode == AUTO_FREQ)  && freq_lock_i  && !s_q.prev_freq) ||
                   ((mode == AUTO_PHASE) && phase_lock_i && !s_q.prev_phase);
        man_hit  = src_ref_i ? ref_rise_i : upd_strobe_i;
        req      = auto_hit | man_hit;
        qual     = apll_ok_i | lock_ovr_i;
        fire     = (req | s_q.pending) & qual;

        s_d            = s_q;
        s_d.prev_freq  = freq_lock_i;
        s_d.prev_phase = phase_lock_i;
        s_d.pending    = auto_on & ~fire & (s_q.pending | req);
        s_d.sync       = fire;
        rel_d          = rel_q | ({NUM_CH{fire}} & ~mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q   <= '0;
            rel_q <= '0;
        end else begin
            s_q   <= s_d;
            rel_q <= rel_d;
        end
    end

    assign sync_o     = s_q.sync;
    assign released_o = rel_q;

endmodule

// File: rtl/odsync_divider.sv
module odsync_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [DIV_W-1:0] ratio_i,
    output logic             clk_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             out;
    } div_state_t;

    div_state_t       s_d, s_q;
    logic [DIV_W-1:0] eff_m1;
    logic             wrap;

    always_comb begin
        eff_m1 = (ratio_i == '0) ? '0 : ratio_i - 1'b1;
        wrap   = (s_q.cnt >= eff_m1);
        s_d    = s_q;
        if (hold_i) begin
            s_d.cnt = '0;
            s_d.out = 1'b0;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.out = ~s_q.out;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clk_o = s_q.out;

endmodule

// File: rtl/odsync_top.sv
module odsync_top #(
    parameter int NUM_CH      = 2,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       cfg_mask_i,
    input  logic                    cfg_src_ref_i,
    input  logic [1:0]              cfg_auto_mode_i,
    input  logic                    cfg_lock_ovr_i,
    input  logic [NUM_CH-1:0]       cfg_out_en_i,
    input  logic [NUM_CH*DIV_W-1:0] cfg_ratio_i,
    input  logic                    upd_strobe_i,
    input  logic                    ref_sync_i,
    input  logic                    freq_lock_i,
    input  logic                    phase_lock_i,
    input  logic                    apll_ok_i,
    output logic [NUM_CH-1:0]       div_hold_o,
    output logic [NUM_CH-1:0]       div_clk_o,
    output logic [NUM_CH-1:0]       drv_en_o
);

    logic              ref_rise_w;
    logic              sync_w;
    logic [NUM_CH-1:0] released_w;

    odsync_ref_sync #(.STAGES(SYNC_STAGES)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ref_sync_i),
        .rise_o  (ref_rise_w)
    );

    odsync_req_ctl #(.NUM_CH(NUM_CH)) u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_ref_i    (cfg_src_ref_i),
        .auto_mode_i  (cfg_auto_mode_i),
        .lock_ovr_i   (cfg_lock_ovr_i),
        .apll_ok_i    (apll_ok_i),
        .upd_strobe_i (upd_strobe_i),
        .ref_rise_i   (ref_rise_w),
        .freq_lock_i  (freq_lock_i),
        .phase_lock_i (phase_lock_i),
        .mask_i       (cfg_mask_i),
        .sync_o       (sync_w),
        .released_o   (released_w)
    );

    // Mask bypasses hold with no clock edge; sync clears all unmasked channels
    assign div_hold_o = ~cfg_mask_i & (~released_w | {NUM_CH{sync_w}});
    assign drv_en_o   = cfg_out_en_i;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_div
        odsync_divider #(.DIV_W(DIV_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold_i  (div_hold_o[ch]),
            .ratio_i (cfg_ratio_i[ch*DIV_W +: DIV_W]),
            .clk_o   (div_clk_o[ch])
        );
    end

endmodule

// File: rtl/odsync_chk.sv
module odsync_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] cfg_mask_i,
    input logic [NUM_CH-1:0] cfg_out_en_i,
    input logic              cfg_lock_ovr_i,
    input logic              apll_ok_i,
    input logic [NUM_CH-1:0] div_hold_o,
    input logic [NUM_CH-1:0] div_clk_o,
    input logic [NUM_CH-1:0] drv_en_o,
    input logic              sync_q
);

    // R8
    qual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |-> $past(apll_ok_i || cfg_lock_ovr_i));

    // R7
    drv_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cfg_mask_i) && $stable(cfg_out_en_i)) |-> $stable(drv_en_o));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        // R2
        hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            div_hold_o[ch] |=> !div_clk_o[ch]);

        // R6
        mask_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_mask_i[ch] |-> !div_hold_o[ch]);
    end

endmodule

bind odsync_top odsync_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_mask_i     (cfg_mask_i),
    .cfg_out_en_i   (cfg_out_en_i),
    .cfg_lock_ovr_i (cfg_lock_ovr_i),
    .apll_ok_i      (apll_ok_i),
    .div_hold_o     (div_hold_o),
    .div_clk_o      (div_clk_o),
    .drv_en_o       (drv_en_o),
    .sync_q         (sync_w)
);

// File: tb/tb_odsync_top.sv
`timescale 1ns/1ps
module tb_odsync_top;

    localparam int NUM_CH = 2;
    localparam int DIV_W  = 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NUM_CH-1:0]       cfg_mask = '0;
    logic                    cfg_src_ref = 1'b0;
    logic [1:0]              cfg_auto = 2'b00;
    logic                    cfg_ovr = 1'b0;
    logic [NUM_CH-1:0]       cfg_oen = '0;
    logic [NUM_CH*DIV_W-1:0] cfg_ratio = '0;
    logic                    strobe = 1'b0;
    logic                    ref_in = 1'b0;
    logic                    flock = 1'b0;
    logic                    plock = 1'b0;
    logic                    apll = 1'b1;
    logic [NUM_CH-1:0]       hold, dclk, den;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    odsync_top #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_mask_i(cfg_mask), .cfg_src_ref_i(cfg_src_ref),
        .cfg_auto_mode_i(cfg_auto), .cfg_lock_ovr_i(cfg_ovr), .cfg_out_en_i(cfg_oen),
        .cfg_ratio_i(cfg_ratio), .upd_strobe_i(strobe), .ref_sync_i(ref_in),
        .freq_lock_i(flock), .phase_lock_i(plock), .apll_ok_i(apll),
        .div_hold_o(hold), .div_clk_o(dclk), .drv_en_o(den)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic nxt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Strobe sync, then compare both channels against (j / N) mod 2
    task automatic sync_wave(input int ra, input int rb);
        int ea, eb;
        ea = (ra == 0) ? 1 : ra;
        eb = (rb == 0) ? 1 : rb;
        cfg_ratio = {rb[DIV_W-1:0], ra[DIV_W-1:0]};
        strobe = 1'b1;
        nxt(1);
        strobe = 1'b0;
        chk("R3 strobe hold", hold, 2'b11);
        nxt(1);
        chk("R10 joint release", hold, 2'b00);
        for (int j = 0; j < 4 * 4; j++) begin
            chk("R2 ch0 wave", dclk[0], (j / ea) % 2);
            chk("R2 ch1 wave", dclk[1], (j / eb) % 2);
            nxt(1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        nxt(2);
        chk("R1 hold in reset", hold, 2'b11);
        chk("R1 clk low in reset", dclk, 2'b00);
        rst_n = 1'b1;
        nxt(3);
        chk("R1 hold after reset", hold, 2'b11);
        chk("R1 clk low after reset", dclk, 2'b00);

        // Divider ratios, both channels, restart alignment
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                sync_wave(a, b);

        // Automatic modes x lock flags
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 2; f++) begin
                cfg_auto = m[1:0];
                flock = 1'b0;
                plock = 1'b0;
                nxt(2);
                if (f == 0) flock = 1'b1; else plock = 1'b1;
                nxt(1);
                chk("R5 auto trigger", hold,
                    ((m == 1 && f == 0) || (m == 2 && f == 1)) ? 2'b11 : 2'b00);
                for (int k = 0; k < 3; k++) begin
                    nxt(1);
                    chk("R5 steady flag no retrigger", hold, 2'b00);
                end
            end
        end
        flock = 1'b0;
        plock = 1'b0;
        cfg_auto = 2'b00;
        nxt(2);

        // Source selection
        cfg_src_ref = 1'b1;
        strobe = 1'b1;
        nxt(1);
        strobe = 1'b0;
        chk("R3 strobe ignored", hold, 2'b00);
        nxt(1);
        ref_in = 1'b1;
        nxt(1); chk("R4 ref stage1", hold, 2'b00);
        nxt(1); chk("R4 ref stage2", hold, 2'b00);
        nxt(1); chk("R4 ref applied", hold, 2'b11);
        nxt(1); chk("R4 ref single", hold, 2'b00);
        ref_in = 1'b0;
        nxt(3);
        cfg_src_ref = 1'b0;
        ref_in = 1'b1;
        for (int k = 0; k < 5; k++) begin
            nxt(1);
            chk("R4 ref ignored", hold, 2'b00);
        end
        ref_in = 1'b0;
        nxt(3);

        // Masking
        cfg_oen = 2'b01;
        cfg_mask = 2'b01;
        #1;
        chk("R7 mask leaves enable", den, 2'b01);
        nxt(1);
        strobe = 1'b1;
        nxt(1);
        strobe = 1'b0;
        chk("R6 masked ch ignores sync", hold, 2'b10);
        cfg_mask = 2'b11;
        #1;
        chk("R7 mask leaves enable", den, 2'b01);
        nxt(1);
        strobe = 1'b1;
        nxt(1);
        strobe = 1'b0;
        chk("R6 all masked", hold, 2'b00);
        cfg_mask = 2'b00;
        nxt(2);

        // Qualification and pending
        apll = 1'b0;
        cfg_auto = 2'b10;
        strobe = 1'b1;
        nxt(1);
        strobe = 1'b0;
        chk("R8 unqualified blocked", hold, 2'b00);
        nxt(2);
        chk("R8 still blocked", hold, 2'b00);
        apll = 1'b1;
        nxt(1);
        chk("R9 pending applied", hold, 2'b11);
        nxt(1);
        chk("R9 pending single", hold, 2'b00);

        apll = 1'b0;
        strobe = 1'b1;
        nxt(1);
        strobe = 1'b0;
        cfg_auto = 2'b00;
        nxt(2);
        apll = 1'b1;
        for (int k = 0; k < 3; k++) begin
            nxt(1);
            chk("R9 pending dropped", hold, 2'b00);
        end

        apll = 1'b0;
        strobe = 1'b1;
        nxt(1);
        strobe = 1'b0;
        apll = 1'b1;
        nxt(1);
        chk("R9 disabled mode no pending", hold, 2'b00);

        apll = 1'b0;
        cfg_ovr = 1'b1;
        strobe = 1'b1;
        nxt(1);
        strobe = 1'b0;
        chk("R8 override applies", hold, 2'b11);
        cfg_ovr = 1'b0;
        apll = 1'b1;
        nxt(2);

        finish_run();
    end

endmodule